// File: doc/BRIEF.md
# Endpoint Byte Count and Status Register

This block is the per-endpoint register that firmware and the serial interface engine share to describe one data packet. It holds a six-bit byte count, a flag that says whether received data passed its CRC check, and the DATA0/DATA1 toggle of the packet. Before an IN transfer, firmware writes the count and toggle of the packet it wants sent. After an OUT or SETUP packet arrives, the engine writes the received byte count including the two CRC bytes, the received toggle and the CRC verdict, and the block raises a one-cycle endpoint interrupt.

A parameter picks between two kinds of instance. A control-endpoint instance refuses CPU writes from the moment the engine posts a status update until the CPU reads the register. This keeps firmware from overwriting a fresh SETUP or OUT status by mistake. A data-endpoint instance has no such lock. A firmware write with a count above the largest packet size is stored as that maximum and reported on an error output.

Top module: `ep_count_status`

## Requirements
- R1: After reset, the register reads 0x00, `ep_irq` and `wr_err` are low, and the register is unlocked.
- R2: The register layout is fixed: bit 7 is the toggle (0 = DATA0, 1 = DATA1), bit 6 is the CRC-good flag, and bits 5:0 are the byte count. `cpu_rdata` always shows the current contents.
- R3: An accepted CPU write stores `cpu_wdata[7]` as the toggle and `cpu_wdata[5:0]` as the count, and it clears bit 6 whatever was written there. The new value can be read in the cycle after the write edge.
- R4: If an accepted CPU write has a count above 32, the stored count is 32 and `wr_err` is high for exactly the next cycle. Writes with a count of 32 or less, and writes that are ignored, leave `wr_err` low.
- R5: A hardware update stores the payload length plus 2 as the count, `hw_toggle` as bit 7 and `hw_crc_ok` as bit 6. A payload length above 32 is treated as 32, so the stored count stays between 2 and 34.
- R6: `ep_irq` is high in exactly the cycle after each edge that samples `hw_upd`, whether the CRC was good or bad, and it is low otherwise.
- R7: On a control instance (`IS_CONTROL`=1), a hardware update locks the register. CPU writes have no effect until an edge that samples `cpu_rd` high, and writes are accepted again from the following edge on.
- R8: When a hardware update and a CPU write fall on the same edge, the hardware update wins. When a hardware update and a CPU read fall on the same edge, the control instance stays locked.
- R9: A data instance (`IS_CONTROL`=0) never locks, so a CPU write after a hardware update is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data: toggle, valid (ignored), count |
| cpu_rd | input | 1 | CPU read strobe; unlocks a control instance |
| cpu_rdata | output | 8 | Current register contents |
| hw_upd | input | 1 | Engine status write after an OUT or SETUP packet |
| hw_payload_len | input | 6 | Received payload bytes, CRC excluded |
| hw_toggle | input | 1 | Received data toggle |
| hw_crc_ok | input | 1 | Received CRC was correct |
| ep_irq | output | 1 | One-cycle endpoint interrupt |
| wr_err | output | 1 | One-cycle flag for an over-size firmware count |

## Verification
Directed sequences first run each kind of access on its own: firmware writes at counts of 21, 32 and 63, hardware updates with good CRC, bad CRC and an over-length payload, and a write to a locked register before and after a read. These cases separate the saturation, the clearing of the valid bit and the lock timing. Same-edge collisions (update with write, update with read) show the priorities. Both instance kinds get identical stimulus, so a lock that leaks into the data instance, or a lock missing from the control instance, shows up as a difference in read data. A seeded random phase then mixes all four strobes and checks every cycle against a bench model.

// File: rtl/ep_count_status.sv
module ep_count_status #(
  parameter bit IS_CONTROL = 1'b1,
  parameter int CNT_W      = 6,
  parameter int MAX_PKT    = 32,
  parameter int CRC_BYTES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [CNT_W+1:0] cpu_wdata,
  input  logic             cpu_rd,
  output logic [CNT_W+1:0] cpu_rdata,
  input  logic             hw_upd,
  input  logic [CNT_W-1:0] hw_payload_len,
  input  logic             hw_toggle,
  input  logic             hw_crc_ok,
  output logic             ep_irq,
  output logic             wr_err
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PKT);
  localparam logic [CNT_W-1:0] CRC_C = CNT_W'(CRC_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             vld_q, tgl_q, lock_q, irq_q, err_q;

  wire              wr_ok  = cpu_wr && !lock_q && !hw_upd;
  wire              wr_big = cpu_wdata[CNT_W-1:0] > MAX_C;
  wire [CNT_W-1:0]  wr_cnt = wr_big ? MAX_C : cpu_wdata[CNT_W-1:0];
  wire [CNT_W-1:0]  rx_len = (hw_payload_len > MAX_C) ? MAX_C : hw_payload_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      tgl_q  <= 1'b0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q <= hw_upd;
      err_q <= wr_ok && wr_big;
      if (hw_upd) begin
        cnt_q <= rx_len + CRC_C;
        tgl_q <= hw_toggle;
        vld_q <= hw_crc_ok;
      end else if (wr_ok) begin
        cnt_q <= wr_cnt;
        tgl_q <= cpu_wdata[CNT_W+1];
        vld_q <= 1'b0;
      end
      if (IS_CONTROL && hw_upd) lock_q <= 1'b1;
      else if (cpu_rd)          lock_q <= 1'b0;
    end
  end

  assign cpu_rdata = {tgl_q, vld_q, cnt_q};
  assign ep_irq    = irq_q;
  assign wr_err    = err_q;
endmodule

module ep_count_status_chk #(
  parameter bit IS_CONTROL = 1'b1,
  parameter int CNT_W      = 6,
  parameter int MAX_PKT    = 32,
  parameter int CRC_BYTES  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [CNT_W+1:0] cpu_wdata,
  input logic             cpu_rd,
  input logic [CNT_W+1:0] cpu_rdata,
  input logic             hw_upd,
  input logic             hw_toggle,
  input logic             hw_crc_ok,
  input logic             ep_irq,
  input logic             wr_err,
  input logic             lock_q
);
  a_r6_irq_follows_upd: assert property (@(posedge clk) disable iff (!rst_n)
    hw_upd |=> ep_irq);
  a_r6_irq_only_after_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_upd |=> !ep_irq);
  a_r5_rx_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> (int'(cpu_rdata[CNT_W-1:0]) >= CRC_BYTES &&
                int'(cpu_rdata[CNT_W-1:0]) <= MAX_PKT + CRC_BYTES));
  a_r5_rx_fields: assert property (@(posedge clk) disable iff (!rst_n)
    hw_upd |=> (cpu_rdata[CNT_W+1] == $past(hw_toggle) && cpu_rdata[CNT_W] == $past(hw_crc_ok)));
  a_r4_err_means_sat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (int'(cpu_rdata[CNT_W-1:0]) == MAX_PKT && !cpu_rdata[CNT_W]));
  a_r7_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !hw_upd) |=> $stable(cpu_rdata));
  a_r9_data_ep_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_CONTROL && cpu_wr && !hw_upd) |=> cpu_rdata[CNT_W+1] == $past(cpu_wdata[CNT_W+1]));
  a_r8_read_with_upd_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_CONTROL && hw_upd && cpu_rd) |=> lock_q);
endmodule

bind ep_count_status ep_count_status_chk #(
  .IS_CONTROL(IS_CONTROL), .CNT_W(CNT_W), .MAX_PKT(MAX_PKT), .CRC_BYTES(CRC_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
  .cpu_rdata(cpu_rdata), .hw_upd(hw_upd), .hw_toggle(hw_toggle), .hw_crc_ok(hw_crc_ok),
  .ep_irq(ep_irq), .wr_err(wr_err), .lock_q(lock_q)
);

// File: tb/ep_count_status_bench.sv
module ep_count_status_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, hw_upd = 1'b0, hw_toggle = 1'b0, hw_crc_ok = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [5:0] hw_payload_len = '0;
  logic [7:0] rd_c, rd_n;
  logic       irq_c, irq_n, err_c, err_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_reg [2];
  logic       m_lock [2], m_irq [2], m_err [2];

  always #(PERIOD/2) clk = ~clk;

  ep_count_status #(.IS_CONTROL(1'b1)) u_ep_count_status (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_rdata(rd_c), .hw_upd(hw_upd), .hw_payload_len(hw_payload_len),
    .hw_toggle(hw_toggle), .hw_crc_ok(hw_crc_ok), .ep_irq(irq_c), .wr_err(err_c));

  ep_count_status #(.IS_CONTROL(1'b0)) u_ep_count_status_nc (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_rdata(rd_n), .hw_upd(hw_upd), .hw_payload_len(hw_payload_len),
    .hw_toggle(hw_toggle), .hw_crc_ok(hw_crc_ok), .ep_irq(irq_n), .wr_err(err_n));

  function automatic logic [5:0] sat32(input logic [5:0] v);
    return (v > 6'd32) ? 6'd32 : v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_reg[i] = 8'h00; m_lock[i] = 0; m_irq[i] = 0; m_err[i] = 0;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      logic acc;
      acc = cpu_wr && !m_lock[i] && !hw_upd;
      m_irq[i] = hw_upd;
      m_err[i] = acc && (cpu_wdata[5:0] > 6'd32);
      if (hw_upd)   m_reg[i] = {hw_toggle, hw_crc_ok, sat32(hw_payload_len) + 6'd2};
      else if (acc) m_reg[i] = {cpu_wdata[7], 1'b0, sat32(cpu_wdata[5:0])};
      if (hw_upd && i == 0) m_lock[i] = 1;
      else if (cpu_rd)      m_lock[i] = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {irq,err,data}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_both(input string tag);
    chk({tag, " ctrl"}, {irq_c, err_c, rd_c}, {m_irq[0], m_err[0], m_reg[0]});
    chk({tag, " data"}, {irq_n, err_n, rd_n}, {m_irq[1], m_err[1], m_reg[1]});
  endtask

  task automatic cyc(input string tag, input logic wr, input logic [7:0] wd, input logic rd,
                     input logic up, input logic [5:0] len, input logic tg, input logic ok);
    cpu_wr = wr; cpu_wdata = wd; cpu_rd = rd;
    hw_upd = up; hw_payload_len = len; hw_toggle = tg; hw_crc_ok = ok;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_both(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_both("R1 reset state");
    // R3, R2: valid bit written 1 is stored as 0
    cyc("R3 write toggle1 count21", 1, 8'hD5, 0, 0, 0, 0, 0);
    chk("R2 layout", {2'b00, rd_c}, {2'b00, 8'h95});
    // R4: over-size saturates, err pulse
    cyc("R4 write 63 saturates", 1, 8'h3F, 0, 0, 0, 0, 0);
    cyc("R4 err falls", 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 write exactly 32", 1, 8'hA0, 0, 0, 0, 0, 0);
    // R5, R6
    cyc("R5 rx good crc", 0, 0, 0, 1, 6'd8, 1, 1);
    chk("R5 value 0xCA", {2'b00, rd_c}, {2'b00, 8'hCA});
    cyc("R6 irq falls", 0, 0, 0, 0, 0, 0, 0);
    // R7: locked write ignored on ctrl, taken on data (R9)
    cyc("R7 locked write", 1, 8'h05, 0, 0, 0, 0, 0);
    chk("R9 data accepts", {2'b00, rd_n}, {2'b00, 8'h05});
    cyc("R6 rx bad crc irq", 0, 0, 0, 1, 6'd0, 0, 0);
    cyc("R5 rx overlength", 0, 0, 0, 1, 6'd40, 1, 1);
    cyc("R7 read unlocks", 0, 0, 1, 0, 0, 0, 0);
    cyc("R7 write after read", 1, 8'h07, 0, 0, 0, 0, 0);
    // R8 collisions
    cyc("R8 upd with write", 1, 8'h11, 0, 1, 6'd4, 0, 1);
    cyc("R8 upd with read", 0, 0, 1, 1, 6'd3, 1, 1);
    cyc("R8 still locked", 1, 8'h09, 0, 0, 0, 0, 0);
    cyc("R8 read", 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 write ok", 1, 8'h3A, 0, 0, 0, 0, 0);
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R3 R5 R7 random", r[0] | r[1], r[15:8], r[2] & r[3], (r[5:4] == 2'b00),
          6'(r[21:16] % 6'd41), r[22], r[23]);
    end
    finish_run();
  end
endmodule